// File: doc/BRIEF.md
# Pulse-frequency boost switch controller

This block produces the gate command for the power switch of a pulse-frequency-modulated boost converter. Its inputs are four digital comparator flags, all asynchronous to the clock: inductor over-current, output over-voltage trip, output over-voltage recovery, and a global shutdown request. Its single output tells the gate driver whether the switch should conduct. Analog sensing, the comparators and the power stage sit outside the block.

The inner loop is a current loop with a fixed off-time. While the switch conducts, an over-current flag turns it off for `OFF_CYC` clock cycles. After that it turns on again. Each turn-on opens a blanking window of `BLANK_CYC` cycles, and the over-current flag is ignored inside it. This keeps a reverse-recovery current spike at turn-on from ending the pulse early. The outer voltage loop inhibits switching once the output goes over its limit. The inhibit is released only when a separate recovery flag reports that the output has dropped back, which gives the loop hysteresis. Shutdown (thermal, logic-supply or battery undervoltage, combined outside the block) overrides every other input. Each flag passes through a two-flop synchronizer before use.

The controller is a five-state machine. HALT: shutdown is active and the switch is off. HOLD: over-voltage inhibit is active and the switch is off. BLANK: the switch is on and over-current is masked. DRIVE: the switch is on and over-current is watched. REST: the fixed off-time is running and the switch is off. Transitions:
- Shutdown: any state goes to HALT.
- Release: HALT or HOLD goes to BLANK once neither shutdown nor inhibit is present.
- Inhibit: HALT, BLANK or DRIVE goes to HOLD.
- Unmask: BLANK goes to DRIVE when the window expires.
- Trip: DRIVE goes to REST on over-current.
- Resume: REST goes to BLANK, or to HOLD if inhibit is present, when the off-time expires.

Top module: `pfm_boost_ctrl`

## Requirements
- R1: `sw_on_o` is 0 while `rst_ni` is low. The shutdown synchronizer resets to the asserted value, so `sw_on_o` also stays 0 at the first two rising edges after reset is released.
- R2: When shutdown and over-voltage inhibit are both clear, the switch turns on, and every turn-on begins with a blanking window.
- R3: For `BLANK_CYC` cycles after each turn-on, the over-current flag has no effect. With over-current held high, every on-pulse lasts exactly `BLANK_CYC`+1 cycles.
- R4: Over-current seen outside the blanking window turns the switch off for exactly `OFF_CYC` cycles. The switch then turns on again if nothing else holds it off. The switch never turns off without over-current, inhibit or shutdown.
- R5: While the synchronized trip flag is high, the switch is off from the next cycle on.
- R6: Once the trip flag has been seen, the inhibit stays in force after the flag falls. It clears only when the recovery flag is seen high while the trip flag is low. If both flags are high, the trip flag wins.
- R7: Shutdown forces the switch off in every state, including blanking and off-time. After release, switching restarts with a blanking window.
- R8: An inhibit raised during the off-time keeps the switch off after the off-time expires, until recovery.
- R9: A flag change at the inputs reaches `sw_on_o` at the third rising edge: two synchronizer stages, then the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oc_flag_i | input | 1 | Inductor over-current comparator flag (async) |
| ov_trip_i | input | 1 | Output above upper voltage limit (async) |
| ov_clear_i | input | 1 | Output below recovery voltage level (async) |
| shutdown_i | input | 1 | Global shutdown request (async) |
| sw_on_o | output | 1 | Boost switch gate command, 1 = conduct |

## Verification
The bench builds the block with `OFF_CYC` = 12 and `BLANK_CYC` = 4, in place of the 250 and 8 defaults. With these values a full off-time plus a blanking window lasts under twenty cycles. The random phase therefore reaches hundreds of trip, inhibit and shutdown interleavings, including shutdown landing inside a blanking window and inhibit rising during an off-time. A blanking length above one keeps masked over-current inside the window distinct from over-current at its last cycle. The off-time is long enough to outlast the two-cycle synchronizer, so a short over-current pulse is fully absorbed within one off-time.

// File: rtl/pfm_boost_pkg.sv
package pfm_boost_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_HALT  = 3'd0,  // shutdown active, switch off
        ST_HOLD  = 3'd1,  // over-voltage inhibit, switch off
        ST_BLANK = 3'd2,  // switch on, current flag masked
        ST_DRIVE = 3'd3,  // switch on, current flag watched
        ST_REST  = 3'd4   // fixed off-time running
    } pfm_state_e;

    // Bit positions inside the synchronized flag vector
    localparam int FLG_OC   = 0;
    localparam int FLG_TRIP = 1;
    localparam int FLG_CLR  = 2;
    localparam int FLG_SD   = 3;
    localparam int FLG_NUM  = 4;

    function automatic logic state_conducts(pfm_state_e s);
        return (s == ST_BLANK) || (s == ST_DRIVE);
    endfunction

endpackage

// File: rtl/pfm_flag_sync.sv
module pfm_flag_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VEC = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                chain_q <= {STAGES{RST_VEC[b]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/pfm_ov_latch.sv
module pfm_ov_latch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trip_i,
    input  logic clear_i,
    output logic inhibit_o
);

    logic held_q;

    // Trip sets, recovery clears, trip dominates
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            held_q <= 1'b0;
        end else if (trip_i) begin
            held_q <= 1'b1;
        end else if (clear_i) begin
            held_q <= 1'b0;
        end
    end

    assign inhibit_o = trip_i | held_q;

endmodule

// File: rtl/pfm_window_timer.sv
module pfm_window_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pfm_boost_ctrl.sv
module pfm_boost_ctrl
    import pfm_boost_pkg::*;
#(
    parameter int OFF_CYC     = 250,
    parameter int BLANK_CYC   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic oc_flag_i,
    input  logic ov_trip_i,
    input  logic ov_clear_i,
    input  logic shutdown_i,
    output logic sw_on_o
);

    localparam int MAX_CYC = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] OFF_LOAD   = CNT_W'(OFF_CYC - 1);
    localparam logic [CNT_W-1:0] BLANK_LOAD = CNT_W'(BLANK_CYC - 1);
    localparam logic [FLG_NUM-1:0] SYNC_RST = FLG_NUM'(1) << FLG_SD;

    logic [FLG_NUM-1:0] flags_async, flags_s;
    logic oc_s, trip_s, clr_s, sd_s;
    logic inhibit;
    logic tmr_done, tmr_load;
    logic [CNT_W-1:0] tmr_val;
    pfm_state_e state_q, state_nxt;

    assign flags_async[FLG_OC]   = oc_flag_i;
    assign flags_async[FLG_TRIP] = ov_trip_i;
    assign flags_async[FLG_CLR]  = ov_clear_i;
    assign flags_async[FLG_SD]   = shutdown_i;

    pfm_flag_sync #(
        .WIDTH  (FLG_NUM),
        .STAGES (SYNC_STAGES),
        .RST_VEC(SYNC_RST)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(flags_async),
        .sync_o (flags_s)
    );

    assign oc_s   = flags_s[FLG_OC];
    assign trip_s = flags_s[FLG_TRIP];
    assign clr_s  = flags_s[FLG_CLR];
    assign sd_s   = flags_s[FLG_SD];

    pfm_ov_latch u_ovl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .trip_i   (trip_s),
        .clear_i  (clr_s),
        .inhibit_o(inhibit)
    );

    // Next-state logic: shutdown, then inhibit, then current loop
    always_comb begin
        state_nxt = state_q;
        if (sd_s) begin
            state_nxt = ST_HALT;
        end else begin
            unique case (state_q)
                ST_HALT:  state_nxt = inhibit ? ST_HOLD : ST_BLANK;
                ST_HOLD:  state_nxt = inhibit ? ST_HOLD : ST_BLANK;
                ST_BLANK: begin
                    if (inhibit)       state_nxt = ST_HOLD;
                    else if (tmr_done) state_nxt = ST_DRIVE;
                end
                ST_DRIVE: begin
                    if (inhibit)   state_nxt = ST_HOLD;
                    else if (oc_s) state_nxt = ST_REST;
                end
                ST_REST: begin
                    if (tmr_done) state_nxt = inhibit ? ST_HOLD : ST_BLANK;
                end
                default: state_nxt = ST_HALT;
            endcase
        end
    end

    // One shared timer for both windows, loaded on entry
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = BLANK_LOAD;
        if (state_nxt != state_q) begin
            if (state_nxt == ST_BLANK) begin
                tmr_load = 1'b1;
                tmr_val  = BLANK_LOAD;
            end else if (state_nxt == ST_REST) begin
                tmr_load = 1'b1;
                tmr_val  = OFF_LOAD;
            end
        end
    end

    pfm_window_timer #(
        .CNT_W(CNT_W)
    ) u_tmr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .done_o    (tmr_done)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Output register, glitch-free gate command
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sw_on_o <= 1'b0;
        end else begin
            sw_on_o <= state_conducts(state_nxt);
        end
    end

endmodule

// File: rtl/pfm_boost_ctrl_chk.sv
module pfm_boost_ctrl_chk
    import pfm_boost_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sw_on,
    input logic       sd_s,
    input logic       oc_s,
    input logic       inhibit,
    input logic       tmr_done,
    input pfm_state_e state
);

    // R7
    shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_s |=> !sw_on);

    // R5
    inhibit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> !sw_on);

    // R3
    blank_keeps_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLANK && !sd_s && !inhibit) |=> sw_on);

    // R4
    rest_keeps_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REST && !tmr_done) |=> !sw_on);

    // R4
    off_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_on) |-> ($past(oc_s) || $past(sd_s) || $past(inhibit)));

    // R2
    on_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_on) |-> ($past(!sd_s) && $past(!inhibit)));

endmodule

bind pfm_boost_ctrl pfm_boost_ctrl_chk u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .sw_on   (sw_on_o),
    .sd_s    (sd_s),
    .oc_s    (oc_s),
    .inhibit (inhibit),
    .tmr_done(tmr_done),
    .state   (state_q)
);

// File: tb/pfm_boost_ctrl_test.sv
module pfm_boost_ctrl_test;

    localparam int OFF_CYC   = 12;
    localparam int BLANK_CYC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc = 1'b0, ovt = 1'b0, ovr = 1'b0, sd = 1'b0;
    logic sw_on;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    pfm_boost_ctrl #(
        .OFF_CYC  (OFF_CYC),
        .BLANK_CYC(BLANK_CYC)
    ) uut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .oc_flag_i (oc),
        .ov_trip_i (ovt),
        .ov_clear_i(ovr),
        .shutdown_i(sd),
        .sw_on_o   (sw_on)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Cycle model built from the requirements
    // modes: 0 off/shutdown, 1 off/inhibit, 2 on/masked, 3 on/watched, 4 off-time
    function automatic int next_mode(int m, bit sdn, bit inh, bit ocn, bit expired);
        if (sdn) return 0;
        case (m)
            0, 1: return inh ? 1 : 2;
            2:    return inh ? 1 : (expired ? 3 : 2);
            3:    return inh ? 1 : (ocn ? 4 : 3);
            4:    return expired ? (inh ? 1 : 2) : 4;
            default: return 0;
        endcase
    endfunction

    int m_mode, m_left, nx;
    bit m_latch, inh;
    bit [3:0] m_s1, m_s2; // {sd, clear, trip, oc}

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_latch = 0;
            m_s1 = 4'b1000; m_s2 = 4'b1000;
        end else begin
            inh = m_s2[1] | m_latch;
            nx = next_mode(m_mode, m_s2[3], inh, m_s2[0], m_left == 0);
            if (nx != m_mode && nx == 2)      m_left = BLANK_CYC - 1;
            else if (nx != m_mode && nx == 4) m_left = OFF_CYC - 1;
            else if (m_left > 0)              m_left--;
            if (m_s2[1])      m_latch = 1;
            else if (m_s2[2]) m_latch = 0;
            m_mode = nx;
            m_s2 = m_s1;
            m_s1 = {sd, ovr, ovt, oc};
        end
    end

    always @(negedge clk) begin
        if (rst_n) check(sw_on == (m_mode == 2 || m_mode == 3), cur_req, sw_on,
                         (m_mode == 2 || m_mode == 3));
    end

    task automatic finish_run;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            bad++;
            $display("FAIL R2 watchdog expired act=0 exp=1");
            finish_run();
        end
    end

    initial begin
        int width;
        void'($urandom(32'd4711));
        // R1 reset state
        tick(4);
        check(sw_on == 1'b0, "R1 in reset", sw_on, 0);
        rst_n = 1'b1;
        tick(1);
        check(sw_on == 1'b0, "R1 edge1", sw_on, 0);
        tick(1);
        check(sw_on == 1'b0, "R1 edge2", sw_on, 0);
        cur_req = "R2";
        tick(1);
        check(sw_on == 1'b1, "R2 first turn-on", sw_on, 1);
        tick(10);

        // R3/R4 pulse widths with over-current held high
        cur_req = "R3";
        oc = 1'b1;
        while (sw_on) tick(1);
        while (!sw_on) tick(1);
        width = 0;
        while (sw_on) begin width++; tick(1); end
        check(width == BLANK_CYC + 1, "R3 on-pulse width", width, BLANK_CYC + 1);
        cur_req = "R4";
        width = 0;
        while (!sw_on) begin width++; tick(1); end
        check(width == OFF_CYC, "R4 off-time width", width, OFF_CYC);
        oc = 1'b0;
        tick(20);

        // R9 latency of shutdown
        cur_req = "R9";
        sd = 1'b1;
        tick(1); check(sw_on == 1'b1, "R9 edge1", sw_on, 1);
        tick(1); check(sw_on == 1'b1, "R9 edge2", sw_on, 1);
        tick(1); check(sw_on == 1'b0, "R9 edge3", sw_on, 0);
        // R7 shutdown hold and restart
        cur_req = "R7";
        tick(8);
        check(sw_on == 1'b0, "R7 held off", sw_on, 0);
        sd = 1'b0;
        tick(2); check(sw_on == 1'b0, "R7 release edge2", sw_on, 0);
        tick(1); check(sw_on == 1'b1, "R7 restart", sw_on, 1);
        // R7 shutdown inside blanking with over-current
        oc = 1'b1; tick(1); sd = 1'b1; tick(6);
        check(sw_on == 1'b0, "R7 shutdown in blank", sw_on, 0);
        oc = 1'b0; sd = 1'b0; tick(20);

        // R5/R6 trip and hysteresis
        cur_req = "R5";
        ovt = 1'b1; tick(4);
        check(sw_on == 1'b0, "R5 trip off", sw_on, 0);
        ovt = 1'b0;
        cur_req = "R6";
        for (int i = 0; i < 15; i++) begin
            tick(1);
            check(sw_on == 1'b0, "R6 hold after trip falls", sw_on, 0);
        end
        ovt = 1'b1; ovr = 1'b1; tick(6);
        check(sw_on == 1'b0, "R6 trip wins", sw_on, 0);
        ovt = 1'b0; tick(1); ovr = 1'b0; tick(8);
        check(sw_on == 1'b1, "R6 recovery", sw_on, 1);
        tick(10);

        // R8 inhibit raised during off-time
        cur_req = "R8";
        oc = 1'b1; tick(1); oc = 1'b0;
        while (sw_on) tick(1);
        ovt = 1'b1; tick(2); ovt = 1'b0;
        tick(OFF_CYC + 5);
        check(sw_on == 1'b0, "R8 stays off after off-time", sw_on, 0);
        ovr = 1'b1; tick(1); ovr = 1'b0; tick(8);
        check(sw_on == 1'b1, "R8 resumes", sw_on, 1);

        // Random phase, checked by the cycle model
        cur_req = "R4 random";
        for (int i = 0; i < 6000; i++) begin
            oc  = ($urandom % 4) == 0;
            ovr = ($urandom % 9) == 0;
            if (($urandom % 45) == 0)  ovt = ~ovt;
            if (($urandom % 160) == 0) sd  = ~sd;
            tick(1);
        end
        oc = 0; ovt = 0; ovr = 1; sd = 0;
        tick(6);
        ovr = 0;
        tick(10);
        check(sw_on == 1'b1, "R2 final on", sw_on, 1);
        finish_run();
    end

endmodule